// File: doc/BRIEF.md
# Descending LIFO Stack with Full/Empty Flags

This block is a last-in-first-out store of `DEPTH` words (eleven by default). The words sit in an internal memory at addresses 0 to `DEPTH-1`. The bottom of the stack is at the high-address end. A stack pointer moves toward address 0 as words are pushed. When the stack is empty the pointer holds `DEPTH`, one position beyond the highest memory word.

A push lowers the pointer by one and then stores the input word at the new pointer. A pop reads the word at the pointer and then raises the pointer by one. The popped word appears on `dout` one cycle after the request and holds there until the next accepted pop.

Two status flags come from the pointer. `full` is set when the pointer reaches 0. `empty` is set when the pointer returns to `DEPTH`. The block refuses a push while full and a pop while empty. A refused request changes nothing in the stack and raises a one-cycle error pulse. A cycle that asks for both push and pop does nothing.

Top module: `lifo_stack`

## Requirements
- R1: After reset `sp` equals `DEPTH`, `empty` is 1, `full` is 0, `err` is 0 and `dout` is 0.
- R2: An accepted push (`push_req`=1, `pop_req`=0, `full`=0) lowers `sp` by one at the next edge and stores `din` in the word addressed by the new `sp`.
- R3: After an accepted push `empty` is 0, and `full` is 1 exactly when the new `sp` is 0.
- R4: An accepted pop (`pop_req`=1, `push_req`=0, `empty`=0) places the word addressed by the current `sp` on `dout` after the next edge and raises `sp` by one.
- R5: After an accepted pop `full` is 0, and `empty` is 1 exactly when the new `sp` equals `DEPTH`.
- R6: A push alone while `full`=1 leaves `sp`, the flags and the stored words unchanged, and drives `err` to 1 for the one following cycle.
- R7: A pop alone while `empty`=1 leaves `sp`, the flags and `dout` unchanged, and drives `err` to 1 for the one following cycle.
- R8: When `push_req` and `pop_req` are both 1, nothing changes (`sp`, flags, `dout`, stored words), and `err` is 0 in the following cycle.
- R9: Accepted pops return words in the reverse order of the accepted pushes that stored them.
- R10: `err` is 0 in any cycle that does not follow a refused request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Push request for this cycle |
| pop_req | input | 1 | Pop request for this cycle |
| din | input | DATA_W | Word to push |
| dout | output | DATA_W | Most recently popped word |
| sp | output | $clog2(DEPTH+1) | Stack pointer |
| full | output | 1 | Stack holds DEPTH words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The properties assume that `push_req` and `pop_req` are known and stable around each rising edge. They also assume that every request lasts exactly one cycle, so each request is judged against the flags of the same cycle. The stimulus changes inputs only at falling edges and issues one operation per cycle. It drives the stack into both boundaries, then pushes into a full stack and pops from an empty one, asserts both requests at both boundaries, and runs a long pseudo-random mix. Pointer values at the boundaries (0 and `DEPTH`) are reached several times.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_CLASH = 2'd3
    } stk_op_e;

    // Both requests together resolve to a clash, which is a no-op.
    function automatic stk_op_e decode_op(input logic push, input logic pop);
        stk_op_e op;
        case ({pop, push})
            2'b01:   op = OP_PUSH;
            2'b10:   op = OP_POP;
            2'b11:   op = OP_CLASH;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/stk_mem.sv
module stk_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 11,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cell_q [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cell_q[wr_addr] <= wr_data;
        end
    end

    // Output word changes only on an accepted read; otherwise it holds.
    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = cell_q[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
    parameter int DEPTH = 11,
    parameter int SP_W  = 4,
    parameter int AW    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_req,
    input  logic            pop_req,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    output logic [SP_W-1:0] sp,
    output logic            full,
    output logic            empty,
    output logic            err
);

    import stk_pkg::*;

    localparam logic [SP_W-1:0] SP_BOTTOM = SP_W'(DEPTH);
    localparam logic [SP_W-1:0] SP_ONE    = SP_W'(1);

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic            full;
        logic            empty;
        logic            err;
    } ctl_t;

    ctl_t            st_d, st_q;
    logic [SP_W-1:0] sp_dn, sp_up;
    stk_op_e         op;

    always_comb begin
        op      = decode_op(push_req, pop_req);
        sp_dn   = st_q.sp - SP_ONE;
        sp_up   = st_q.sp + SP_ONE;
        st_d    = st_q;
        st_d.err = 1'b0;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_addr = AW'(sp_dn);
        rd_addr = AW'(st_q.sp);
        case (op)
            OP_PUSH: begin
                if (st_q.full) begin
                    st_d.err = 1'b1;
                end else begin
                    wr_en      = 1'b1;
                    st_d.sp    = sp_dn;
                    st_d.full  = (sp_dn == '0);
                    st_d.empty = 1'b0;
                end
            end
            OP_POP: begin
                if (st_q.empty) begin
                    st_d.err = 1'b1;
                end else begin
                    rd_en      = 1'b1;
                    st_d.sp    = sp_up;
                    st_d.empty = (sp_up == SP_BOTTOM);
                    st_d.full  = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp    <= SP_BOTTOM;
            st_q.full  <= 1'b0;
            st_q.empty <= 1'b1;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp    = st_q.sp;
    assign full  = st_q.full;
    assign empty = st_q.empty;
    assign err   = st_q.err;

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 11,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int AW    = SP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [SP_W-1:0]   sp,
    output logic              full,
    output logic              empty,
    output logic              err
);

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;

    stk_ctrl #(.DEPTH(DEPTH), .SP_W(SP_W), .AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_req(push_req),
        .pop_req (pop_req),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .sp      (sp),
        .full    (full),
        .empty   (empty),
        .err     (err)
    );

    stk_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(din),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(dout)
    );

endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 11,
    parameter int SP_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic              pop_req,
    input logic [DATA_W-1:0] dout,
    input logic [SP_W-1:0]   sp,
    input logic              full,
    input logic              empty,
    input logic              err
);

    p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !full) |=> (sp == $past(sp) - SP_W'(1)));

    p_push_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !full) |=> (!empty && (full == (sp == '0))));

    p_pop_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !empty) |=> (sp == $past(sp) + SP_W'(1)));

    p_pop_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !empty) |=> (!full && (empty == (sp == SP_W'(DEPTH)))));

    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && full) |=> (err && full && $stable(sp)));

    p_empty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && empty) |=> (err && empty && $stable(sp) && $stable(dout)));

    p_clash_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req) |=> (!err && $stable(sp) && $stable(dout)));

    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !((push_req && !pop_req && full) || (pop_req && !push_req && empty)) |=> !err);

endmodule

bind lifo_stack stk_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_req(push_req),
    .pop_req (pop_req),
    .dout    (dout),
    .sp      (sp),
    .full    (full),
    .empty   (empty),
    .err     (err)
);

// File: tb/sim_lifo_stack.sv
`timescale 1ns/1ps
module sim_lifo_stack;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 11;
    localparam int SP_W   = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_req = 1'b0;
    logic              pop_req = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic [SP_W-1:0]   sp;
    logic              full, empty, err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model
    int q[$];
    int exp_dout = 0;
    int exp_err  = 0;

    always #4 clk = ~clk;

    lifo_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .din(din), .dout(dout), .sp(sp), .full(full), .empty(empty), .err(err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string t_sp, input string t_fl, input string t_do, input string t_er);
        chk(t_sp, "sp", int'(sp), DEPTH - q.size());
        chk(t_fl, "full", int'(full), int'(q.size() == DEPTH));
        chk(t_fl, "empty", int'(empty), int'(q.size() == 0));
        chk(t_do, "dout", int'(dout), exp_dout);
        chk(t_er, "err", int'(err), exp_err);
    endtask

    // One operation per cycle; inputs set at negedge, outputs sampled at the next negedge.
    task automatic step(input bit ps, input bit pp, input int d);
        string t_sp, t_fl, t_do, t_er;
        push_req = ps;
        pop_req  = pp;
        din      = DATA_W'(d);
        @(posedge clk);
        t_sp = "R10"; t_fl = "R10"; t_do = "R10"; t_er = "R10";
        exp_err = 0;
        if (ps && pp) begin
            t_sp = "R8"; t_fl = "R8"; t_do = "R8"; t_er = "R8";
        end else if (ps) begin
            if (q.size() == DEPTH) begin
                exp_err = 1;
                t_sp = "R6"; t_fl = "R6"; t_do = "R6"; t_er = "R6";
            end else begin
                q.push_back(d & 8'hFF);
                t_sp = "R2"; t_fl = "R3"; t_do = "R2";
            end
        end else if (pp) begin
            if (q.size() == 0) begin
                exp_err = 1;
                t_sp = "R7"; t_fl = "R7"; t_do = "R7"; t_er = "R7";
            end else begin
                exp_dout = q.pop_back();
                t_sp = "R4"; t_fl = "R5"; t_do = "R9";
            end
        end
        @(negedge clk);
        compare(t_sp, t_fl, t_do, t_er);
    endtask

    initial begin
        int lfsr;
        int r;
        @(negedge clk);
        @(negedge clk);
        compare("R1", "R1", "R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", "R1", "R1", "R1");

        // short LIFO run
        step(1, 0, 8'h11);
        step(1, 0, 8'h22);
        step(1, 0, 8'h33);
        step(0, 0, 0);
        step(0, 1, 0);
        step(0, 1, 0);
        step(1, 0, 8'h44);
        step(0, 1, 0);
        step(0, 1, 0);

        // empty boundary
        step(0, 1, 0);
        step(0, 1, 0);
        step(1, 1, 8'h55);
        step(0, 0, 0);

        // fill to full
        for (int i = 0; i < DEPTH; i++) step(1, 0, 8'hA0 + i);
        step(1, 0, 8'hEE);
        step(1, 0, 8'hEF);
        step(1, 1, 8'hED);
        step(0, 0, 0);
        // drain
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0);
        step(0, 1, 0);
        step(0, 0, 0);

        // pseudo-random mix, biased toward pushes then pops
        lfsr = 32'h1ACE;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r = lfsr & 7;
            if (i % 200 < 100) step(r < 5, r >= 4, (lfsr >> 8) & 8'hFF);
            else               step(r >= 6, r < 4 || r == 7, (lfsr >> 8) & 8'hFF);
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule